// File: doc/BRIEF.md
# Two-Stage Watchdog Countdown Timer

This block is a supervision timer with two chained countdown stages. Software enables it and then has to kick it at intervals. If no kick comes before the first stage runs out, the block raises a warning interrupt of a programmable kind and starts the second stage at once. If the second stage also runs out, the block asks for a system reset and records that request in a sticky flag. That flag survives the ordinary reset, so software can learn after the restart why the system went down. An optional free-run mode starts the first stage again after the second one ends.

There are two 20-bit preload registers, one per stage. A stage length in clock cycles is its preload shifted left by 15 in slow scale, or by 5 in fast scale. Both preloads reset to all ones. A control word holds lock, enable and free-run. A config word holds the reboot-disable bit, the scale select and the warning type. Once lock is set, control writes have no effect until the next reset. Bus decoding and any unlock handshake sit outside this block.

Top module: `twostage_wdog`

## Requirements
- R1: After `rst` with `pwr_rst`, the block is disabled and unlocked, with reboot enabled, slow scale and warning type 0. `ctl_rdata` and `cfg_rdata` read 0. `warn_irq`, `warn_smi`, `rst_req` and `prev_rst` are low.
- R2: A control write that changes enable (bit 1) from 0 to 1 loads stage 1. The warning pulse appears exactly N1 cycles after the loading edge, where N1 is preload 1 scaled. A preload of zero expires one cycle after the load.
- R3: Stage 2 is loaded on the edge of the warning. `rst_req` pulses exactly N2 cycles later, where N2 is preload 2 scaled.
- R4: The warning type is config bits [1:0]. Type 0 pulses `warn_irq`, type 2 pulses `warn_smi`, and types 1 and 3 pulse neither. In every type, stage 2 still runs.
- R5: Config bit 2 = 0 selects slow scale (preload << 15). Config bit 2 = 1 selects fast scale (preload << 5).
- R6: Config bit 5 = 1 disables reboot. Stage-2 expiry then gives no `rst_req` and leaves `prev_rst` unchanged.
- R7: With free-run (control bit 2) set, stage-2 expiry starts stage 1 again, so the warning and reset cycle repeats. With free-run clear, the block halts after one warning and one reset request.
- R8: A `kick` pulse while the block is enabled reloads stage 1 from preload 1. A kick while the block is disabled has no effect.
- R9: A control write with enable = 0 stops the countdown, and no pulses follow. A write with enable = 1 while the block is already enabled does not restart the count.
- R10: Once lock (control bit 0) is set, every later control write is ignored until `rst`.
- R11: `prev_rst` is set together with `rst_req`. It is kept through `rst`. It is cleared only by `flag_clr` or by `pwr_rst`.
- R12: `warn_irq`, `warn_smi` and `rst_req` are single-cycle pulses.
- R13: The readback words use the write layout. `ctl_rdata` is {free-run, enable, lock}. `cfg_rdata` is {reboot-disable, 0, 0, fast, type[1:0]}, and config bits 4:3 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one cycle is the base tick |
| rst | input | 1 | Synchronous reset; the sticky flag is kept |
| pwr_rst | input | 1 | Power-on reset; also clears the sticky flag |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 3 | Control data {free-run, enable, lock} |
| ctl_rdata | output | 3 | Control word readback |
| cfg_we | input | 1 | Config word write strobe |
| cfg_wdata | input | 6 | Config data {reboot-disable, -, -, fast, type[1:0]} |
| cfg_rdata | output | 6 | Config word readback |
| pld1_we | input | 1 | Write strobe for the stage-1 preload |
| pld2_we | input | 1 | Write strobe for the stage-2 preload |
| pld_wdata | input | 20 | Preload write data |
| kick | input | 1 | Keep-alive pulse |
| flag_clr | input | 1 | Clears the sticky previous-reset flag |
| warn_irq | output | 1 | Stage-1 expiry pulse for warning type 0 |
| warn_smi | output | 1 | Stage-1 expiry pulse for warning type 2 |
| rst_req | output | 1 | Stage-2 expiry reset request pulse |
| prev_rst | output | 1 | Sticky flag: a reset request has occurred |

## Verification
The assertions check a set of rules on every cycle. Each pulse lasts one cycle, and the two warning outputs never fire together. Each warning agrees with the type that was configured one edge earlier. The sticky flag rises only with a reset request. A locked control word stays frozen, and a disabled block stays silent. The exact lengths of each stage under both scales can only be shown by the bench scenarios. The same holds for the warn-then-reset order, free-run repetition against halting, the effect of kicks and redundant enables, and the flag surviving `rst`. The bench measures these against the cycle counts that follow from the preloads.

// File: rtl/twd_pkg.sv
package twd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ONE  = 2'd1,
    ST_TWO  = 2'd2,
    ST_DONE = 2'd3
  } twd_state_e;

  localparam logic [1:0] ACT_IRQ = 2'd0;
  localparam logic [1:0] ACT_SMI = 2'd2;
endpackage

// File: rtl/twd_regs.sv
module twd_regs #(
  parameter int PW = 20,
  parameter logic [PW-1:0] PRE_RST = {PW{1'b1}}
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ctl_we,
  input  logic [2:0]    ctl_wdata,
  input  logic          cfg_we,
  input  logic [5:0]    cfg_wdata,
  input  logic          pld1_we,
  input  logic          pld2_we,
  input  logic [PW-1:0] pld_wdata,
  output logic          lock_q,
  output logic          en_q,
  output logic          free_q,
  output logic          rbdis_q,
  output logic          fast_q,
  output logic [1:0]    act_q,
  output logic [PW-1:0] pre1_q,
  output logic [PW-1:0] pre2_q,
  output logic          go,
  output logic          halt
);
  logic ctl_ok;
  assign ctl_ok = ctl_we && !lock_q;
  assign go     = ctl_ok && ctl_wdata[1] && !en_q;
  assign halt   = ctl_ok && !ctl_wdata[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      lock_q  <= 1'b0;
      en_q    <= 1'b0;
      free_q  <= 1'b0;
      rbdis_q <= 1'b0;
      fast_q  <= 1'b0;
      act_q   <= 2'd0;
      pre1_q  <= PRE_RST;
      pre2_q  <= PRE_RST;
    end else begin
      if (ctl_ok) begin
        lock_q <= ctl_wdata[0];
        en_q   <= ctl_wdata[1];
        free_q <= ctl_wdata[2];
      end
      if (cfg_we) begin
        rbdis_q <= cfg_wdata[5];
        fast_q  <= cfg_wdata[2];
        act_q   <= cfg_wdata[1:0];
      end
      if (pld1_we) pre1_q <= pld_wdata;
      if (pld2_we) pre2_q <= pld_wdata;
    end
  end
endmodule

// File: rtl/twd_count.sv
module twd_count #(
  parameter int CW = 35
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          dec,
  output logic          last
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)                      cnt <= '0;
    else if (load)                cnt <= load_val;
    else if (dec && cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign last = (cnt <= CW'(1));
endmodule

// File: rtl/twd_seq.sv
module twd_seq
  import twd_pkg::*;
#(
  parameter int PW         = 20,
  parameter int SLOW_SHIFT = 15,
  parameter int FAST_SHIFT = 5,
  localparam int CW        = PW + SLOW_SHIFT
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pwr_rst,
  input  logic          en_q,
  input  logic          go,
  input  logic          halt,
  input  logic          kick,
  input  logic          last,
  input  logic          free_q,
  input  logic          rbdis_q,
  input  logic          fast_q,
  input  logic [1:0]    act_q,
  input  logic [PW-1:0] pre1_q,
  input  logic [PW-1:0] pre2_q,
  input  logic          flag_clr,
  output logic          load,
  output logic [CW-1:0] load_val,
  output logic          dec,
  output logic          warn_irq,
  output logic          warn_smi,
  output logic          rst_req,
  output logic          prev_rst
);
  twd_state_e st, st_n;
  logic       sel2, warn_evt, rst_evt;
  logic [PW-1:0] pre_sel;

  function automatic logic [CW-1:0] scale(input logic [PW-1:0] p, input logic f);
    return f ? (CW'(p) << FAST_SHIFT) : (CW'(p) << SLOW_SHIFT);
  endfunction

  always_comb begin
    st_n     = st;
    load     = 1'b0;
    sel2     = 1'b0;
    warn_evt = 1'b0;
    rst_evt  = 1'b0;
    if (halt) begin
      st_n = ST_IDLE;
    end else if (go || (kick && en_q)) begin
      st_n = ST_ONE;
      load = 1'b1;
    end else if (en_q) begin
      case (st)
        ST_ONE: if (last) begin
          st_n     = ST_TWO;
          load     = 1'b1;
          sel2     = 1'b1;
          warn_evt = 1'b1;
        end
        ST_TWO: if (last) begin
          rst_evt = !rbdis_q;
          if (free_q) begin
            st_n = ST_ONE;
            load = 1'b1;
          end else begin
            st_n = ST_DONE;
          end
        end
        default: ;
      endcase
    end else begin
      st_n = ST_IDLE;
    end
  end

  assign pre_sel  = sel2 ? pre2_q : pre1_q;
  assign load_val = scale(pre_sel, fast_q);
  assign dec      = (st == ST_ONE || st == ST_TWO) && !load;

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      warn_irq <= 1'b0;
      warn_smi <= 1'b0;
      rst_req  <= 1'b0;
    end else begin
      st       <= st_n;
      warn_irq <= warn_evt && (act_q == ACT_IRQ);
      warn_smi <= warn_evt && (act_q == ACT_SMI);
      rst_req  <= rst_evt;
    end
  end

  always_ff @(posedge clk) begin
    if (pwr_rst)        prev_rst <= 1'b0;
    else if (rst_evt)   prev_rst <= 1'b1;
    else if (flag_clr)  prev_rst <= 1'b0;
  end
endmodule

// File: rtl/twostage_wdog.sv
module twostage_wdog #(
  parameter int PW         = 20,
  parameter int SLOW_SHIFT = 15,
  parameter int FAST_SHIFT = 5,
  localparam int CW        = PW + SLOW_SHIFT
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pwr_rst,
  input  logic          ctl_we,
  input  logic [2:0]    ctl_wdata,
  output logic [2:0]    ctl_rdata,
  input  logic          cfg_we,
  input  logic [5:0]    cfg_wdata,
  output logic [5:0]    cfg_rdata,
  input  logic          pld1_we,
  input  logic          pld2_we,
  input  logic [PW-1:0] pld_wdata,
  input  logic          kick,
  input  logic          flag_clr,
  output logic          warn_irq,
  output logic          warn_smi,
  output logic          rst_req,
  output logic          prev_rst
);
  logic          any_rst;
  logic          lock_q, en_q, free_q, rbdis_q, fast_q, go, halt;
  logic [1:0]    act_q;
  logic [PW-1:0] pre1_q, pre2_q;
  logic          load, dec, last;
  logic [CW-1:0] load_val;

  assign any_rst = rst | pwr_rst;

  twd_regs #(.PW(PW)) u_regs (
    .clk(clk), .rst(any_rst),
    .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .pld1_we(pld1_we), .pld2_we(pld2_we), .pld_wdata(pld_wdata),
    .lock_q(lock_q), .en_q(en_q), .free_q(free_q),
    .rbdis_q(rbdis_q), .fast_q(fast_q), .act_q(act_q),
    .pre1_q(pre1_q), .pre2_q(pre2_q), .go(go), .halt(halt)
  );

  twd_count #(.CW(CW)) u_count (
    .clk(clk), .rst(any_rst), .load(load), .load_val(load_val),
    .dec(dec), .last(last)
  );

  twd_seq #(.PW(PW), .SLOW_SHIFT(SLOW_SHIFT), .FAST_SHIFT(FAST_SHIFT)) u_seq (
    .clk(clk), .rst(any_rst), .pwr_rst(pwr_rst),
    .en_q(en_q), .go(go), .halt(halt), .kick(kick), .last(last),
    .free_q(free_q), .rbdis_q(rbdis_q), .fast_q(fast_q), .act_q(act_q),
    .pre1_q(pre1_q), .pre2_q(pre2_q), .flag_clr(flag_clr),
    .load(load), .load_val(load_val), .dec(dec),
    .warn_irq(warn_irq), .warn_smi(warn_smi),
    .rst_req(rst_req), .prev_rst(prev_rst)
  );

  assign ctl_rdata = {free_q, en_q, lock_q};
  assign cfg_rdata = {rbdis_q, 2'b00, fast_q, act_q};
endmodule

// File: rtl/twd_chk.sv
module twd_chk (
  input logic       clk,
  input logic       rst,
  input logic       pwr_rst,
  input logic       warn_irq,
  input logic       warn_smi,
  input logic       rst_req,
  input logic       prev_rst,
  input logic [2:0] ctl_rdata,
  input logic [5:0] cfg_rdata
);
  p_pulse_warn_r12: assert property (@(posedge clk) disable iff (rst || pwr_rst)
    warn_irq |=> !warn_irq);
  p_pulse_smi_r12: assert property (@(posedge clk) disable iff (rst || pwr_rst)
    warn_smi |=> !warn_smi);
  p_pulse_rst_r12: assert property (@(posedge clk) disable iff (rst || pwr_rst)
    rst_req |=> !rst_req);
  p_one_action_r4: assert property (@(posedge clk) disable iff (rst || pwr_rst)
    !(warn_irq && warn_smi));
  p_irq_type_r4: assert property (@(posedge clk) disable iff (rst || pwr_rst)
    warn_irq |-> ($past(cfg_rdata[1:0]) == 2'd0));
  p_smi_type_r4: assert property (@(posedge clk) disable iff (rst || pwr_rst)
    warn_smi |-> ($past(cfg_rdata[1:0]) == 2'd2));
  p_flag_set_r11: assert property (@(posedge clk) disable iff (rst || pwr_rst)
    rst_req |-> prev_rst);
  p_flag_rise_r11: assert property (@(posedge clk) disable iff (rst || pwr_rst)
    $rose(prev_rst) |-> rst_req);
  p_lock_hold_r10: assert property (@(posedge clk) disable iff (rst || pwr_rst)
    ctl_rdata[0] |=> $stable(ctl_rdata));
  p_quiet_off_r9: assert property (@(posedge clk) disable iff (rst || pwr_rst)
    !ctl_rdata[1] |-> (!warn_irq && !warn_smi && !rst_req));
endmodule

bind twostage_wdog twd_chk u_chk (.*);

// File: tb/twostage_wdog_tb_top.sv
module twostage_wdog_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 6;
  // p1, p2, type, rbdis, rel. irq, rel. smi, rel. rst (-1 = none); fast scale
  localparam int VEC [NV][7] = '{
    '{2, 3, 0, 0,  64, -1, 160},
    '{1, 1, 2, 0,  -1, 32,  64},
    '{3, 2, 3, 0,  -1, -1, 160},
    '{1, 4, 1, 0,  -1, -1, 160},
    '{2, 1, 0, 1,  64, -1,  -1},
    '{0, 0, 0, 0,   1, -1,   2}
  };

  logic clk = 1'b0, rst = 1'b1, pwr_rst = 1'b1;
  logic ctl_we = 1'b0, cfg_we = 1'b0, pld1_we = 1'b0, pld2_we = 1'b0;
  logic kick = 1'b0, flag_clr = 1'b0;
  logic [2:0] ctl_wdata = '0;
  logic [5:0] cfg_wdata = '0;
  logic [19:0] pld_wdata = '0;
  logic [2:0] ctl_rdata;
  logic [5:0] cfg_rdata;
  logic warn_irq, warn_smi, rst_req, prev_rst;

  int cyc = 0, n_chk = 0, n_bad = 0;
  int t_irq, t_smi, t_rst, n_irq, n_smi, n_rst, wid_err = 0;
  logic l_irq = 0, l_smi = 0, l_rst = 0;
  int s;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  twostage_wdog dut_i (.*);

  always @(negedge clk) begin
    if (warn_irq) begin n_irq++; if (t_irq < 0) t_irq = cyc; end
    if (warn_smi) begin n_smi++; if (t_smi < 0) t_smi = cyc; end
    if (rst_req)  begin n_rst++; if (t_rst < 0) t_rst = cyc; end
    if ((warn_irq && l_irq) || (warn_smi && l_smi) || (rst_req && l_rst)) wid_err++;
    l_irq = warn_irq; l_smi = warn_smi; l_rst = rst_req;
  end

  task automatic clr_mon();
    t_irq = -1; t_smi = -1; t_rst = -1; n_irq = 0; n_smi = 0; n_rst = 0;
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int rel(input int t, input int base);
    return (t < 0) ? -1 : t - base;
  endfunction

  task automatic do_reset(input logic pwr);
    @(negedge clk); rst = 1'b1; pwr_rst = pwr;
    tick(2); rst = 1'b0; pwr_rst = 1'b0;
    tick(1);
  endtask

  task automatic wr_cfg(input logic [5:0] v);
    cfg_we = 1'b1; cfg_wdata = v; @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic wr_ctl(input logic [2:0] v);
    ctl_we = 1'b1; ctl_wdata = v; @(negedge clk); ctl_we = 1'b0;
  endtask

  task automatic wr_pld(input int p1, input int p2);
    pld1_we = 1'b1; pld_wdata = 20'(p1); @(negedge clk); pld1_we = 1'b0;
    pld2_we = 1'b1; pld_wdata = 20'(p2); @(negedge clk); pld2_we = 1'b0;
  endtask

  // drives a control write, returns the cycle index of the loading edge
  task automatic start_ctl(input logic [2:0] v, output int st);
    ctl_we = 1'b1; ctl_wdata = v;
    @(posedge clk); #1 st = cyc;
    @(negedge clk); ctl_we = 1'b0;
  endtask

  task automatic kick_now(output int st);
    kick = 1'b1;
    @(posedge clk); #1 st = cyc;
    @(negedge clk); kick = 1'b0;
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not finish");
    summary();
    $finish;
  end

  initial begin
    int s2;
    clr_mon();
    tick(3);
    rst = 1'b0; pwr_rst = 1'b0;
    tick(1);
    // R1 reset state
    chk("R1 pulses", {29'd0, warn_irq, warn_smi, rst_req}, 0);
    chk("R1 ctl", ctl_rdata, 0);
    chk("R1 cfg", cfg_rdata, 0);
    chk("R1 flag", prev_rst, 0);

    // vector table: R2 R3 R4 R6
    for (int i = 0; i < NV; i++) begin
      do_reset(1'b1);
      clr_mon();
      wr_cfg({VEC[i][3] != 0, 2'b00, 1'b1, 2'(VEC[i][2])});
      wr_pld(VEC[i][0], VEC[i][1]);
      start_ctl(3'b010, s);
      tick(300);
      chk("R2/R4 warn_irq time", rel(t_irq, s), VEC[i][4]);
      chk("R4 warn_smi time", rel(t_smi, s), VEC[i][5]);
      chk("R3/R6 rst_req time", rel(t_rst, s), VEC[i][6]);
      chk("R6/R11 flag", prev_rst, VEC[i][6] >= 0 ? 1 : 0);
    end

    // R5 slow scale
    do_reset(1'b1); clr_mon();
    wr_cfg(6'b000000); wr_pld(1, 1);
    start_ctl(3'b010, s);
    tick(65600);
    chk("R5 slow warn", rel(t_irq, s), 32768);
    chk("R5 slow rst", rel(t_rst, s), 65536);

    // R7 free-run repeats, non-free halts
    do_reset(1'b1); clr_mon();
    wr_cfg(6'b000100); wr_pld(1, 1);
    start_ctl(3'b110, s);
    tick(200);
    chk("R7 free warns", n_irq, 3);
    chk("R7 free resets", n_rst, 3);
    do_reset(1'b1); clr_mon();
    wr_cfg(6'b000100); wr_pld(1, 1);
    start_ctl(3'b010, s);
    tick(200);
    chk("R7 halt warns", n_irq, 1);
    chk("R7 halt resets", n_rst, 1);

    // R8 kick while enabled reloads, while disabled ignored
    do_reset(1'b1); clr_mon();
    wr_cfg(6'b000100); wr_pld(2, 20);
    start_ctl(3'b010, s);
    tick(40);
    kick_now(s2);
    tick(120);
    chk("R8 kick reload", rel(t_irq, s2), 64);
    do_reset(1'b1); clr_mon();
    wr_cfg(6'b000100); wr_pld(0, 0);
    kick_now(s2);
    tick(100);
    chk("R8 kick disabled", n_irq + n_rst, 0);
    chk("R8 kick disabled ctl", ctl_rdata, 0);

    // R9 disable stops; redundant enable does not restart
    do_reset(1'b1); clr_mon();
    wr_cfg(6'b000100); wr_pld(2, 2);
    start_ctl(3'b010, s);
    tick(30);
    wr_ctl(3'b000);
    tick(200);
    chk("R9 stopped", n_irq + n_rst, 0);
    clr_mon();
    start_ctl(3'b010, s);
    tick(40);
    wr_ctl(3'b010);
    tick(100);
    chk("R9 no restart", rel(t_irq, s), 64);

    // R10 lock
    do_reset(1'b1); clr_mon();
    wr_cfg(6'b000100); wr_pld(2, 2);
    start_ctl(3'b011, s);
    wr_ctl(3'b000);
    chk("R10 locked ctl", ctl_rdata, 3);
    tick(200);
    chk("R10 locked still runs", rel(t_irq, s), 64);
    do_reset(1'b0);
    chk("R10 unlocked by rst", ctl_rdata, 0);
    wr_ctl(3'b100);
    chk("R10 writable", ctl_rdata, 4);

    // R11 sticky flag
    do_reset(1'b1); clr_mon();
    wr_cfg(6'b000100); wr_pld(1, 1);
    start_ctl(3'b010, s);
    tick(100);
    chk("R11 set", prev_rst, 1);
    do_reset(1'b0);
    chk("R11 kept by rst", prev_rst, 1);
    flag_clr = 1'b1; @(negedge clk); flag_clr = 1'b0;
    chk("R11 flag_clr", prev_rst, 0);
    wr_cfg(6'b000100); wr_pld(1, 1);
    start_ctl(3'b010, s);
    tick(100);
    chk("R11 set again", prev_rst, 1);
    do_reset(1'b1);
    chk("R11 pwr_rst clears", prev_rst, 0);

    // R13 readback layout
    wr_cfg(6'b100110);
    chk("R13 cfg", cfg_rdata, 6'b100110);
    wr_cfg(6'b011001);
    chk("R13 cfg unused bits", cfg_rdata, 6'b000001);
    wr_ctl(3'b110);
    chk("R13 ctl", ctl_rdata, 3'b110);

    // R12 pulse width across the whole run
    chk("R12 pulse width", wid_err, 0);

    summary();
    $finish;
  end
endmodule